// File: doc/BRIEF.md
# D-Channel Status and Interrupt Register

This block holds the eight status flags that a D-channel link controller shows to its host. The receive byte buffer, the transmit byte buffer, the receive packet queue and the line idle detectors each report events or live levels to it. Each flag follows its own rule. Some flags latch an event and hold it until the host reads the register. Some copy a live condition from the datapath. Two flags are set by one line event and cleared by another.

A per-bit enable mask selects which flags drive a single level-sensitive interrupt request. Only six of the eight flags can ever raise it. The host samples `status_o` in the cycle in which it pulses `rd_stb_i`. That pulse clears the read-sensitive flags on the next clock edge. An event that arrives in the same cycle as the read is kept, not lost.

Top module: `dchan_status_reg`

## Requirements
- R1: After an asynchronous reset (`rst_n` low), `status_o` reads 0x10: bit 4 is 1 and all other bits are 0.
- R2: A pulse on `rx_last_rd_i` sets bit 0 on the next clock edge. The bit then holds until a host read.
- R3: A pulse on `rx_lost_i` sets bit 2 and a pulse on `tx_last_i` sets bit 3. Bits 0, 2 and 3 clear on the clock edge that follows a cycle with `rd_stb_i` high.
- R4: If a set pulse for bit 0, 2 or 3 arrives in the same cycle as `rd_stb_i`, that bit is 1 after the edge.
- R5: Bit 1 follows `rx_avail_i`, bit 4 follows `tx_space_i` and bit 7 follows `rx_second_i`, each one clock later.
- R6: Bit 5 is set by `mark_set_i` and cleared by `mark_clr_i`. A host read leaves it unchanged.
- R7: Bit 6 is set by `flag_set_i` and cleared by `flag_clr_i`. A host read leaves it unchanged.
- R8: If a set and a clear for bit 5 or bit 6 arrive in the same cycle, the bit is 1 after the edge.
- R9: `irq_o` is high exactly when some status bit among 0, 1, 2, 3, 4 and 7 is 1 and its enable bit `irq_en_i[n]` is 1.
- R10: Bits 5 and 6 never raise `irq_o`, whatever their enables are.
- R11: When `idle_i` is high at a clock edge, `status_o` returns to 0x10 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | Idle mode; returns all flags to their defaults |
| rd_stb_i | input | 1 | Host read of the status register |
| rx_last_rd_i | input | 1 | Pulse: last byte of a received packet was read |
| rx_lost_i | input | 1 | Pulse: a third packet arrived while two were pending |
| tx_last_i | input | 1 | Pulse: last byte of a transmit packet left the buffer |
| rx_avail_i | input | 1 | Level: receive byte buffer is not empty |
| tx_space_i | input | 1 | Level: transmit byte buffer can take a byte |
| rx_second_i | input | 1 | Level: a second packet has started in the receive queue |
| mark_set_i | input | 1 | Pulse: 15 contiguous ones seen on the line |
| mark_clr_i | input | 1 | Pulse: a zero bit seen on the line |
| flag_set_i | input | 1 | Pulse: more than two contiguous flags seen |
| flag_clr_i | input | 1 | Pulse: a character that is not a flag seen |
| irq_en_i | input | 8 | Per-bit interrupt enables |
| status_o | output | 8 | Status register value |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A host read and a new event for the same read-sensitive flag can fall in the same cycle. The read then has to clear the flag while the event has to set it. The bench drives `rd_stb_i` together with `rx_last_rd_i`, `rx_lost_i` or `tx_last_i` at one falling edge. At the next falling edge it checks that the flag is 1 and that the other read-sensitive flags have cleared. The bench provokes the same conflict on the mark and flag idle bits by pulsing their set and clear inputs together.

// File: rtl/dstat_pkg.sv
package dstat_pkg;
   localparam int unsigned STAT_W = 8;

   localparam int unsigned B_RX_LAST  = 0;
   localparam int unsigned B_RX_AVAIL = 1;
   localparam int unsigned B_RX_LOST  = 2;
   localparam int unsigned B_TX_LAST  = 3;
   localparam int unsigned B_TX_SPACE = 4;
   localparam int unsigned B_MARK     = 5;
   localparam int unsigned B_FLAG     = 6;
   localparam int unsigned B_SECOND   = 7;

   // which flags copy a live level rather than latch events
   localparam logic [STAT_W-1:0] LEVEL_BITS  = 8'b1001_0010;
   // which latched flags clear on a host read
   localparam logic [STAT_W-1:0] READ_CLEAR  = 8'b0000_1101;
   // which flags may raise the interrupt
   localparam logic [STAT_W-1:0] IRQ_CAPABLE = 8'b1001_1111;
   localparam logic [STAT_W-1:0] DEFAULT_VAL = 8'h10;
endpackage

// File: rtl/dstat_bit.sv
module dstat_bit #(
   parameter bit   IS_LEVEL = 1'b0,
   parameter logic RST_VAL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_i,
   input  logic set_i,
   input  logic clr_i,
   input  logic lvl_i,
   output logic q_o
);
   logic q_next;

   // latched flags give set priority over clear
   always_comb begin
      if (IS_LEVEL) q_next = lvl_i;
      else          q_next = set_i | (q_o & ~clr_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= RST_VAL;
      else if (idle_i) q_o <= RST_VAL;
      else             q_o <= q_next;
   end
endmodule

// File: rtl/dstat_irq.sv
module dstat_irq #(
   parameter int unsigned         W   = 8,
   parameter logic [W-1:0]        CAP = '1
) (
   input  logic [W-1:0] status_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   assign irq_o = |(status_i & en_i & CAP);
endmodule

// File: rtl/dchan_status_reg.sv
module dchan_status_reg
   import dstat_pkg::*;
#(
   parameter int unsigned            W         = STAT_W,
   parameter logic [STAT_W-1:0]      RESET_VAL = DEFAULT_VAL,
   parameter logic [STAT_W-1:0]      LVL_MASK  = LEVEL_BITS,
   parameter logic [STAT_W-1:0]      RD_MASK   = READ_CLEAR,
   parameter logic [STAT_W-1:0]      IRQ_MASK  = IRQ_CAPABLE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         idle_i,
   input  logic         rd_stb_i,
   input  logic         rx_last_rd_i,
   input  logic         rx_lost_i,
   input  logic         tx_last_i,
   input  logic         rx_avail_i,
   input  logic         tx_space_i,
   input  logic         rx_second_i,
   input  logic         mark_set_i,
   input  logic         mark_clr_i,
   input  logic         flag_set_i,
   input  logic         flag_clr_i,
   input  logic [7:0]   irq_en_i,
   output logic [7:0]   status_o,
   output logic         irq_o
);
   if (W != STAT_W) begin : g_bad_width
      $error("dchan_status_reg: W must equal %0d", STAT_W);
   end
   if ((LVL_MASK & RD_MASK) != '0) begin : g_bad_masks
      $error("dchan_status_reg: a level flag cannot clear on read");
   end

   logic [W-1:0] set_vec, clr_vec, lvl_vec, stat_q;

   always_comb begin
      set_vec = '0;
      set_vec[B_RX_LAST] = rx_last_rd_i;
      set_vec[B_RX_LOST] = rx_lost_i;
      set_vec[B_TX_LAST] = tx_last_i;
      set_vec[B_MARK]    = mark_set_i;
      set_vec[B_FLAG]    = flag_set_i;

      clr_vec = rd_stb_i ? RD_MASK : '0;
      clr_vec[B_MARK] = clr_vec[B_MARK] | mark_clr_i;
      clr_vec[B_FLAG] = clr_vec[B_FLAG] | flag_clr_i;

      lvl_vec = '0;
      lvl_vec[B_RX_AVAIL] = rx_avail_i;
      lvl_vec[B_TX_SPACE] = tx_space_i;
      lvl_vec[B_SECOND]   = rx_second_i;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      dstat_bit #(
         .IS_LEVEL (LVL_MASK[i]),
         .RST_VAL  (RESET_VAL[i])
      ) u_bit (
         .clk    (clk),
         .rst_n  (rst_n),
         .idle_i (idle_i),
         .set_i  (set_vec[i]),
         .clr_i  (clr_vec[i]),
         .lvl_i  (lvl_vec[i]),
         .q_o    (stat_q[i])
      );
   end

   dstat_irq #(.W(W), .CAP(IRQ_MASK)) u_irq (
      .status_i (stat_q),
      .en_i     (irq_en_i),
      .irq_o    (irq_o)
   );

   assign status_o = stat_q;
endmodule

// File: rtl/dstat_chk.sv
module dstat_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       idle_i,
   input logic       rd_stb_i,
   input logic       rx_last_rd_i,
   input logic       rx_avail_i,
   input logic       mark_set_i,
   input logic       mark_clr_i,
   input logic [7:0] irq_en_i,
   input logic [7:0] status_o,
   input logic       irq_o
);
   a_r1_reset_value: assert property (@(posedge clk)
      !rst_n |=> (status_o == 8'h10));

   a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_last_rd_i && !idle_i) |=> status_o[0]);

   a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && !rx_last_rd_i && !idle_i) |=> !status_o[0]);

   a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_i |=> (status_o[1] == $past(rx_avail_i)));

   a_r6_read_keeps_mark: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && !mark_set_i && !mark_clr_i && !idle_i) |=> $stable(status_o[5]));

   a_r9_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i == 8'h00) |-> !irq_o);

   a_r10_idle_bits_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o & 8'b1001_1111) == 8'h00) |-> !irq_o);

   a_r11_idle_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      idle_i |=> (status_o == 8'h10));
endmodule

bind dchan_status_reg dstat_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .idle_i       (idle_i),
   .rd_stb_i     (rd_stb_i),
   .rx_last_rd_i (rx_last_rd_i),
   .rx_avail_i   (rx_avail_i),
   .mark_set_i   (mark_set_i),
   .mark_clr_i   (mark_clr_i),
   .irq_en_i     (irq_en_i),
   .status_o     (status_o),
   .irq_o        (irq_o)
);

// File: tb/tb_dchan_status_reg.sv
module tb_dchan_status_reg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic idle_i = 0, rd_stb_i = 0, rx_last_rd_i = 0, rx_lost_i = 0, tx_last_i = 0;
   logic rx_avail_i = 0, tx_space_i = 1, rx_second_i = 0;
   logic mark_set_i = 0, mark_clr_i = 0, flag_set_i = 0, flag_clr_i = 0;
   logic [7:0] irq_en_i = 8'h00;
   logic [7:0] status_o;
   logic       irq_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   dchan_status_reg dut (
      .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .rd_stb_i(rd_stb_i),
      .rx_last_rd_i(rx_last_rd_i), .rx_lost_i(rx_lost_i), .tx_last_i(tx_last_i),
      .rx_avail_i(rx_avail_i), .tx_space_i(tx_space_i), .rx_second_i(rx_second_i),
      .mark_set_i(mark_set_i), .mark_clr_i(mark_clr_i),
      .flag_set_i(flag_set_i), .flag_clr_i(flag_clr_i),
      .irq_en_i(irq_en_i), .status_o(status_o), .irq_o(irq_o)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic chk1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic host_read();
      rd_stb_i = 1; step(); rd_stb_i = 0;
   endtask

   task automatic t_reset();
      chk8("R1 reset value", status_o, 8'h10);
      chk1("R10 no irq at reset", irq_o, 1'b0);
   endtask

   task automatic t_sticky();
      rx_last_rd_i = 1; step(); rx_last_rd_i = 0;
      chk8("R2 bit0 set", status_o, 8'h11);
      step(); step();
      chk8("R2 bit0 holds", status_o, 8'h11);
      rx_lost_i = 1; tx_last_i = 1; step(); rx_lost_i = 0; tx_last_i = 0;
      chk8("R3 bits2,3 set", status_o, 8'h1D);
      host_read();
      chk8("R3 read clears", status_o, 8'h10);
   endtask

   task automatic t_collide();
      rx_lost_i = 1; tx_last_i = 1; step(); rx_lost_i = 0; tx_last_i = 0;
      rd_stb_i = 1; rx_last_rd_i = 1; step(); rd_stb_i = 0; rx_last_rd_i = 0;
      chk8("R4 set beats read bit0", status_o, 8'h11);
      rd_stb_i = 1; tx_last_i = 1; step(); rd_stb_i = 0; tx_last_i = 0;
      chk8("R4 set beats read bit3", status_o, 8'h18);
      host_read();
      chk8("R4 cleared after", status_o, 8'h10);
   endtask

   task automatic t_levels();
      rx_avail_i = 1; rx_second_i = 1; tx_space_i = 0; step();
      chk8("R5 levels follow", status_o, 8'h82);
      host_read();
      chk8("R5 read leaves levels", status_o, 8'h82);
      rx_avail_i = 0; rx_second_i = 0; tx_space_i = 1; step();
      chk8("R5 levels drop", status_o, 8'h10);
   endtask

   task automatic t_idle_bits();
      mark_set_i = 1; step(); mark_set_i = 0;
      chk8("R6 mark set", status_o, 8'h30);
      host_read();
      chk8("R6 read keeps mark", status_o, 8'h30);
      mark_clr_i = 1; flag_set_i = 1; step(); mark_clr_i = 0; flag_set_i = 0;
      chk8("R7 flag set mark clr", status_o, 8'h50);
      host_read();
      chk8("R7 read keeps flag", status_o, 8'h50);
      flag_clr_i = 1; step(); flag_clr_i = 0;
      chk8("R7 flag clr", status_o, 8'h10);
      mark_set_i = 1; mark_clr_i = 1; flag_set_i = 1; flag_clr_i = 1; step();
      mark_set_i = 0; mark_clr_i = 0; flag_set_i = 0; flag_clr_i = 0;
      chk8("R8 set wins", status_o, 8'h70);
   endtask

   task automatic t_irq();
      // status now 0x70: only bits 4,5,6
      irq_en_i = 8'h60; #1;
      chk1("R10 bits5,6 no irq", irq_o, 1'b0);
      irq_en_i = 8'h10; #1;
      chk1("R9 bit4 enabled", irq_o, 1'b1);
      irq_en_i = 8'hEF; #1;
      chk1("R9 bit4 masked", irq_o, 1'b0);
      irq_en_i = 8'h04;
      rx_lost_i = 1; step(); rx_lost_i = 0;
      chk1("R9 bit2 raises", irq_o, 1'b1);
      host_read();
      chk1("R9 irq drops after read", irq_o, 1'b0);
      irq_en_i = 8'h80; rx_second_i = 1; step();
      chk1("R9 bit7 raises", irq_o, 1'b1);
      rx_second_i = 0; step();
      chk1("R9 bit7 drops", irq_o, 1'b0);
      irq_en_i = 8'h00;
   endtask

   task automatic t_idle_mode();
      rx_last_rd_i = 1; rx_lost_i = 1; rx_avail_i = 1; step();
      rx_last_rd_i = 0; rx_lost_i = 0;
      chk8("R11 prior state", status_o, 8'h77);
      idle_i = 1; step(); idle_i = 0; rx_avail_i = 0;
      chk8("R11 idle defaults", status_o, 8'h10);
      step();
      rx_last_rd_i = 1; step(); rx_last_rd_i = 0;
      rst_n = 0; #1;
      chk8("R1 async reset", status_o, 8'h10);
      step(); rst_n = 1; step();
   endtask

   initial begin
      step(); step();
      rst_n = 1;
      step();
      t_reset();
      t_sticky();
      t_collide();
      t_levels();
      t_idle_bits();
      t_irq();
      t_idle_mode();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule